// File: doc/BRIEF.md
# High-Resolution PWM Compare Generator

This block produces one pulse-width-modulated output from a 32-bit compare word, using two cascaded prescalers. The first prescaler divides the system clock by `hr_div` to give the fine step. The second counts `lr_div` fine steps to make one loop. A loop counter advances once per loop and runs from zero up to a programmed maximum, so each PWM period lasts `hr × lr × (cnt_max + 1)` system clocks.

The upper 25 bits of the compare word pick the loop in which the output edge falls. The low 7 bits place that edge, in whole fine steps, inside the chosen loop. The compare word passes through a shadow register that is reloaded only when the loop counter wraps. A program can therefore rewrite the word at any time without cutting a period short or producing a double edge. At each wrap the output returns to its programmed idle level, so `cmp_word` sets the duty and `cnt_max` sets the period.

Top module: `hrpwm_gen`

## Requirements
- R1: One fine step lasts `hr_div` clocks and one loop lasts `hr_div × lr_div` clocks. A value of zero on either input counts as one. The PWM period is `hr × lr × (cnt_max + 1)` clocks.
- R2: The loop counter starts at 0, goes up by one at the end of each loop, and goes back to 0 after the loop in which it equals `cnt_max`. It holds its value between loop ends.
- R3: Let C = `cmp[31:7]`, F = `cmp[6:0]` and n = (C·lr + F)·hr. The output leaves its idle level n+1 clocks after the period starts, which is the first edge of the new period. This happens only when the loop counter is at C and the prescaler is at the start of fine step F.
- R4: If F is lr or more, the edge is placed in the last fine step of the loop (step lr−1).
- R5: At each wrap the output goes back to the idle level. If the edge and the wrap fall on the same clock, the wrap wins and no pulse appears.
- R6: The compare word in use is reloaded from `cmp_word` only at a wrap. Reset sets it to all ones, so the first period after reset has no pulse.
- R7: If C is greater than `cnt_max`, the output stays at the idle level for the whole period.
- R8: The idle level is `init_pol`: 0 gives an active-high pulse and 1 gives an active-low pulse. During reset the output equals `init_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hr_div | input | 3 | Fine-step divide value (0 counts as 1) |
| lr_div | input | 7 | Fine steps per loop (0 counts as 1) |
| cmp_word | input | 32 | Compare word: bits 31:7 select the loop, bits 6:0 select the fine step |
| cnt_max | input | 25 | Last loop count value before the wrap |
| init_pol | input | 1 | Idle output level |
| pwm_out | output | 1 | PWM output |

## Verification
The bench aims at these edge placements and boundary conditions:
- **Fine field at or above `lr_div`.** A design that does not clamp it would never fire, or would fire in the wrong step.
- **Edge that lands on the wrap clock.** A wrong priority would leave a one-clock glitch.
- **Coarse value past `cnt_max`.** A wrong compare would produce a pulse in a period that should stay idle.
- **Zero prescale values.** Mishandled zeros would make the period run away.
- **Compare word rewritten mid-period.** A design without the shadow register would move that period's edge instead of waiting for the next wrap.
- **Idle period after reset.** A missing or wrong reset value in the shadow register would produce an edge in the first period.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;

   // Selects how the compare word reaches the edge logic
   typedef enum logic {
      CMP_LIVE   = 1'b0,
      CMP_SHADOW = 1'b1
   } cmp_mode_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hrpwm_prescale.sv
module hrpwm_prescale #(
   parameter int HR_W = 3,
   parameter int LR_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [HR_W-1:0] hr_div,
   input  logic [LR_W-1:0] lr_div,
   output logic [LR_W-1:0] lr_cnt,
   output logic [LR_W-1:0] lr_eff,
   output logic            step_start,
   output logic            loop_end
);

   logic [HR_W-1:0] hr_cnt;
   logic [HR_W-1:0] hr_eff;
   logic            hr_last;
   logic            lr_last;

   // zero divide values behave as one
   assign hr_eff = (hr_div == '0) ? HR_W'(1) : hr_div;
   assign lr_eff = (lr_div == '0) ? LR_W'(1) : lr_div;

   // >= keeps the counters bounded if a divide value shrinks on the fly
   assign hr_last = (hr_cnt >= hr_eff - HR_W'(1));
   assign lr_last = (lr_cnt >= lr_eff - LR_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hr_cnt <= '0;
         lr_cnt <= '0;
      end else if (hr_last) begin
         hr_cnt <= '0;
         if (lr_last) lr_cnt <= '0;
         else         lr_cnt <= lr_cnt + LR_W'(1);
      end else begin
         hr_cnt <= hr_cnt + HR_W'(1);
      end
   end

   assign step_start = (hr_cnt == '0);
   assign loop_end   = hr_last && lr_last;

endmodule

// File: rtl/hrpwm_loop_cnt.sv
module hrpwm_loop_cnt #(
   parameter int CNT_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loop_end,
   input  logic [CNT_W-1:0] cnt_max,
   output logic [CNT_W-1:0] loop_cnt,
   output logic             wrap
);

   assign wrap = loop_end && (loop_cnt >= cnt_max);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        loop_cnt <= '0;
      else if (wrap)     loop_cnt <= '0;
      else if (loop_end) loop_cnt <= loop_cnt + CNT_W'(1);
   end

endmodule

// File: rtl/hrpwm_edge.sv
module hrpwm_edge
   import hrpwm_pkg::*;
#(
   parameter int        CMP_W  = 32,
   parameter int        FINE_W = 7,
   parameter int        CNT_W  = 25,
   parameter int        LR_W   = 7,
   parameter cmp_mode_e MODE   = CMP_SHADOW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMP_W-1:0] cmp_word,
   input  logic             wrap,
   input  logic [CNT_W-1:0] loop_cnt,
   input  logic [LR_W-1:0]  lr_cnt,
   input  logic [LR_W-1:0]  lr_eff,
   input  logic             step_start,
   input  logic             init_pol,
   output logic [CMP_W-1:0] cmp_act,
   output logic             pwm_out
);

   localparam int SW = imax(LR_W, FINE_W);

   logic [SW-1:0] fine_w;
   logic [SW-1:0] lr_w;
   logic [SW-1:0] step_sel;
   logic          hit;
   logic          active;

   // compare source: shadowed (reloaded at wrap) or taken straight from the port
   if (MODE == CMP_SHADOW) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cmp_act <= '1;
         else if (wrap) cmp_act <= cmp_word;
      end
   end else begin : g_live
      assign cmp_act = cmp_word;
   end

   // fine field clamped to the last step of the loop
   assign fine_w   = SW'(cmp_act[FINE_W-1:0]);
   assign lr_w     = SW'(lr_eff);
   assign step_sel = (fine_w >= lr_w) ? (lr_w - SW'(1)) : fine_w;

   assign hit = step_start
             && (loop_cnt == cmp_act[CMP_W-1:FINE_W])
             && (SW'(lr_cnt) == step_sel);

   // wrap has priority over the edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    active <= 1'b0;
      else if (wrap) active <= 1'b0;
      else if (hit)  active <= 1'b1;
   end

   assign pwm_out = active ^ init_pol;

endmodule

// File: rtl/hrpwm_gen.sv
module hrpwm_gen
   import hrpwm_pkg::*;
#(
   parameter int        HR_W   = 3,
   parameter int        LR_W   = 7,
   parameter int        CMP_W  = 32,
   parameter int        FINE_W = 7,
   parameter int        CNT_W  = 25,
   parameter cmp_mode_e MODE   = CMP_SHADOW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [HR_W-1:0]  hr_div,
   input  logic [LR_W-1:0]  lr_div,
   input  logic [CMP_W-1:0] cmp_word,
   input  logic [CNT_W-1:0] cnt_max,
   input  logic             init_pol,
   output logic             pwm_out
);

   // elaboration-time parameter checks
   if (CNT_W != CMP_W - FINE_W) begin : g_bad_cnt_w
      $error("hrpwm_gen: CNT_W must equal CMP_W - FINE_W");
   end
   if (FINE_W < 1 || FINE_W >= CMP_W) begin : g_bad_fine_w
      $error("hrpwm_gen: FINE_W out of range");
   end
   if (HR_W < 1 || LR_W < 1) begin : g_bad_div_w
      $error("hrpwm_gen: divider widths must be positive");
   end

   logic [LR_W-1:0]  lr_cnt;
   logic [LR_W-1:0]  lr_eff;
   logic             step_start;
   logic             loop_end;
   logic [CNT_W-1:0] loop_cnt;
   logic             wrap;
   logic [CMP_W-1:0] cmp_act;

   hrpwm_prescale #(
      .HR_W (HR_W),
      .LR_W (LR_W)
   ) i_prescale (
      .clk        (clk),
      .rst_n      (rst_n),
      .hr_div     (hr_div),
      .lr_div     (lr_div),
      .lr_cnt     (lr_cnt),
      .lr_eff     (lr_eff),
      .step_start (step_start),
      .loop_end   (loop_end)
   );

   hrpwm_loop_cnt #(
      .CNT_W (CNT_W)
   ) i_loop_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .loop_end (loop_end),
      .cnt_max  (cnt_max),
      .loop_cnt (loop_cnt),
      .wrap     (wrap)
   );

   hrpwm_edge #(
      .CMP_W  (CMP_W),
      .FINE_W (FINE_W),
      .CNT_W  (CNT_W),
      .LR_W   (LR_W),
      .MODE   (MODE)
   ) i_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_word   (cmp_word),
      .wrap       (wrap),
      .loop_cnt   (loop_cnt),
      .lr_cnt     (lr_cnt),
      .lr_eff     (lr_eff),
      .step_start (step_start),
      .init_pol   (init_pol),
      .cmp_act    (cmp_act),
      .pwm_out    (pwm_out)
   );

endmodule

// File: rtl/hrpwm_gen_chk.sv
module hrpwm_gen_chk
   import hrpwm_pkg::*;
#(
   parameter int        CMP_W = 32,
   parameter int        CNT_W = 25,
   parameter cmp_mode_e MODE  = CMP_SHADOW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             loop_end,
   input logic             wrap,
   input logic [CNT_W-1:0] loop_cnt,
   input logic [CNT_W-1:0] cnt_max,
   input logic             step_start,
   input logic [CMP_W-1:0] cmp_act,
   input logic             init_pol,
   input logic             pwm_out
);

   // R2
   loop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_end && (loop_cnt < cnt_max)) |=> (loop_cnt == CNT_W'($past(loop_cnt) + 1'b1)));

   // R2
   loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_end |=> $stable(loop_cnt));

   // R5
   wrap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ((pwm_out ^ init_pol) == 1'b0));

   // R3
   edge_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out ^ init_pol) |-> $past(step_start));

   if (MODE == CMP_SHADOW) begin : g_shadow_chk
      // R6
      cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wrap |=> $stable(cmp_act));
   end

endmodule

bind hrpwm_gen hrpwm_gen_chk #(
   .CMP_W (CMP_W),
   .CNT_W (CNT_W),
   .MODE  (MODE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .loop_end   (loop_end),
   .wrap       (wrap),
   .loop_cnt   (loop_cnt),
   .cnt_max    (cnt_max),
   .step_start (step_start),
   .cmp_act    (cmp_act),
   .init_pol   (init_pol),
   .pwm_out    (pwm_out)
);

// File: tb/test_hrpwm_gen.sv
module test_hrpwm_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  hr_div = 3'd1;
   logic [6:0]  lr_div = 7'd1;
   logic [31:0] cmp_word = '1;
   logic [24:0] cnt_max = '0;
   logic        init_pol = 1'b0;
   logic        pwm_out;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int base = 0;
   bit last = 1'b0;
   bit done = 1'b0;

   // scoreboard: expected output transitions
   int    exp_cyc[$];
   bit    exp_lvl[$];
   string exp_req[$];

   always #2 clk = ~clk;   // 250 MHz

   hrpwm_gen i_hrpwm_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .hr_div   (hr_div),
      .lr_div   (lr_div),
      .cmp_word (cmp_word),
      .cnt_max  (cnt_max),
      .init_pol (init_pol),
      .pwm_out  (pwm_out)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: every output transition must match the front of the queue
   always @(negedge clk) begin
      if (rst_n && !done && (pwm_out !== last)) begin
         if (exp_cyc.size() == 0) begin
            check(1'b0, "R3", "unexpected edge at cycle", cyc - base, -1);
         end else begin
            check((cyc - base) == exp_cyc[0] && pwm_out == exp_lvl[0],
                  exp_req[0], "edge cycle", cyc - base, exp_cyc[0]);
            check(pwm_out == exp_lvl[0], exp_req[0], "edge level",
                  int'(pwm_out), int'(exp_lvl[0]));
            void'(exp_cyc.pop_front());
            void'(exp_lvl.pop_front());
            void'(exp_req.pop_front());
         end
         last = pwm_out;
      end
   end

   // driver: computes expected edges from the requirements, then runs the case
   task automatic run_case(input string req, input int hr, input int lr, input int mx,
                           input bit pol, input int ca, input int fa,
                           input int cb, input int fb, input int nper, input int sw);
      int he, le, per;
      he  = (hr == 0) ? 1 : hr;   // R1: zero counts as one
      le  = (lr == 0) ? 1 : lr;
      per = he * le * (mx + 1);
      rst_n    = 1'b0;
      hr_div   = 3'(hr);
      lr_div   = 7'(lr);
      cnt_max  = 25'(mx);
      init_pol = pol;
      cmp_word = {25'(ca), 7'(fa)};
      @(negedge clk);
      @(negedge clk);
      check(pwm_out === pol, "R8", "level in reset", int'(pwm_out), int'(pol));
      exp_cyc.delete(); exp_lvl.delete(); exp_req.delete();
      // R6: period 0 idle; periods 1..sw use A, later ones use B
      for (int p = 1; p < nper; p++) begin
         int c, f, n;
         c = (p <= sw) ? ca : cb;
         f = (p <= sw) ? fa : fb;
         if (f >= le) f = le - 1;        // R4
         if (c <= mx) begin              // R7
            n = (c * le + f) * he;
            if (n + 1 < per) begin       // R5: wrap wins on a tie
               exp_cyc.push_back(p * per + n + 1); exp_lvl.push_back(!pol); exp_req.push_back(req);
               exp_cyc.push_back((p + 1) * per);   exp_lvl.push_back(pol);  exp_req.push_back("R5");
            end
         end
      end
      last  = pol;
      base  = cyc;
      rst_n = 1'b1;
      for (int k = 1; k <= nper * per; k++) begin
         @(negedge clk);
         if (k == sw * per + per / 2) cmp_word = {25'(cb), 7'(fb)};
      end
      #1;
      check(pwm_out == pol, "R5", "idle level after wrap", int'(pwm_out), int'(pol));
      rst_n = 1'b0;
      check(exp_cyc.size() == 0, req, "missing edges", exp_cyc.size(), 0);
   endtask

   initial begin
      // R3: basic placement, hr=2 lr=4, coarse 1 fine 2 -> rise 13, fall 32
      run_case("R3", 2, 4, 3, 1'b0, 1, 2, 1, 2, 4, 99);
      // R8: active-low output, coarse 0 fine 0 -> edge on first clock
      run_case("R8", 1, 5, 2, 1'b1, 0, 0, 0, 0, 4, 99);
      // R4: fine field equal to lr clamps to last step
      run_case("R4", 3, 3, 1, 1'b0, 1, 3, 1, 3, 4, 99);
      // R7: coarse beyond max never fires
      run_case("R7", 2, 2, 3, 1'b0, 5, 0, 5, 0, 3, 99);
      // R5: edge and wrap on the same clock -> no pulse
      run_case("R5", 1, 4, 2, 1'b0, 2, 3, 2, 3, 4, 99);
      // R6: compare rewritten mid-period takes effect at the next wrap
      run_case("R6", 2, 2, 4, 1'b0, 1, 0, 3, 1, 5, 2);
      // R1: zero divide values behave as one, large fine clamps to 0
      run_case("R1", 0, 0, 5, 1'b0, 2, 9, 2, 9, 4, 99);
      // R2: longer loops, fine at lr-1 boundary without clamp
      run_case("R2", 5, 10, 2, 1'b1, 0, 9, 1, 0, 4, 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule